// File: doc/BRIEF.md
# Serial Register-Port Master

This block is the host-side master of a four-wire serial control port. It lets on-chip logic read and write 8-bit configuration registers inside attached radio baseband devices. The bus uses a serial clock, a read/write strobe, one shared bidirectional data line and one active-low select per device. The data line leaves the block as a driven value, an output enable and a returned input, so the pad sits outside.

A request carries a direction flag, a 6-bit register index, write data and a target number. It enters through a valid/ready handshake. `req_ready` is high only while no frame is in progress. A request is taken on a clock where `req_valid` and `req_ready` are both high. While a frame runs, `req_ready` stays low and `req_valid` has no effect. The result comes back as a one-cycle `rsp_valid` pulse with `rsp_rdata`. The response has no back-pressure: the consumer must take it in the pulse cycle. `rsp_rdata` then holds its value until the next request is accepted.

Each frame lasts 36 half-periods of the serial clock. One half-period is `HALF_DIV` system clocks. The frame has one idle clock period with the select low, then 16 clock pulses, then one idle period before the select is released. Both sides use only the rising edge. The master changes the data line on a rising edge, and the receiver samples on a rising edge.

Top module: `serial_regport_master`

## Requirements
- R1: After reset, every `cs_n` bit is 1, `sclk`, `rw`, `sd_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: During a frame, exactly one `cs_n` bit is low: the bit numbered by the accepted `req_target`. `sclk` and the data line are shared by all targets.
- R3: A frame has exactly 16 rising `sclk` edges. On edges 1 to 8 the bus carries the address byte {0, index[5:0], 0}, most significant bit first. On edges 9 to 16 it carries the data byte, most significant bit first.
- R4: While `sd_oe` stays high, `sd_o` changes only together with a rising `sclk` edge.
- R5: In a write frame, `rw` stays 0 and `sd_oe` stays 1 for as long as the select is low. The target stores `req_wdata`.
- R6: In a read frame, `rw` rises after rising edge 7 and before rising edge 8. `sd_oe` falls with edge 8 and stays 0 to the end of the frame. The master captures the bits present at edges 9 to 16 into `rsp_rdata`, bit 7 first.
- R7: The select goes low at least `2*HALF_DIV` system clocks before the first rising edge. It stays low at least `2*HALF_DIV` clocks after the last falling edge. `sclk` is 0 whenever no select is low.
- R8: `req_ready` is 1 exactly when no select is low. A request presented while `req_ready` is 0 starts no frame and changes no register.
- R9: `rsp_valid` is a single-cycle pulse, one per frame. `rsp_rdata` is the read byte after a read and 0 after a write. It keeps that value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | TGT_W | Target device number |
| req_index | input | 6 | Register index (address bits 6..1) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, held until next accept |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_TGT | Active-low per-target selects |
| rw | output | 1 | Read/write strobe, high for reads |
| sd_o | output | 1 | Data value driven to the pad |
| sd_oe | output | 1 | Data pad output enable |
| sd_i | input | 1 | Data value read from the pad |

## Verification
The bench builds the block with `HALF_DIV = 2` and `NUM_TGT = 3`. The short divider keeps every frame at 72 system clocks, so writes, readbacks on all three targets and extreme indexes fit well inside the run time. Three targets exercise a target number above 1 and a select pattern that is not a single pair. The divider of 2 still leaves two system clocks in each half-period, so the bench target can sample the data line before the master's change and drive it on the edge the requirements name.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int IDX_W  = 6;
  localparam int BYTE_W = 8;
  localparam int HCNT_W = 6;
  // half-period indexes inside one frame
  localparam logic [HCNT_W-1:0] H_FIRST_RISE = 6'd2;
  localparam logic [HCNT_W-1:0] H_RW_RISE    = 6'd15;
  localparam logic [HCNT_W-1:0] H_RELEASE    = 6'd16;
  localparam logic [HCNT_W-1:0] H_FIRST_CAP  = 6'd18;
  localparam logic [HCNT_W-1:0] H_LAST_SHIFT = 6'd30;
  localparam logic [HCNT_W-1:0] H_LAST_RISE  = 6'd32;
  localparam logic [HCNT_W-1:0] H_LAST       = 6'd35;

  typedef struct packed {
    logic              write;
    logic [IDX_W-1:0]  index;
    logic [BYTE_W-1:0] wdata;
  } srm_req_t;

  function automatic logic [2*BYTE_W-1:0] srm_frame_word(srm_req_t r);
    return {1'b0, r.index, 1'b0, (r.write ? r.wdata : {BYTE_W{1'b0}})};
  endfunction
endpackage

// File: rtl/srm_tick.sv
module srm_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (run) begin
      if (cnt == LAST)       cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/srm_sequencer.sv
module srm_sequencer
  import srm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  output logic              busy,
  output logic [HCNT_W-1:0] hcnt,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hcnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        hcnt <= '0;
      end else if (busy && tick) begin
        if (hcnt == H_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/srm_shifter.sv
module srm_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift_en,
  input  logic         cap_en,
  input  logic         sd_i,
  output logic         sd_o,
  output logic [W/2-1:0] cap_data
);
  logic [W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx       <= '0;
      cap_data <= '0;
    end else begin
      if (load) begin
        tx       <= load_word;
        cap_data <= '0;
      end else begin
        if (shift_en) tx       <= {tx[W-2:0], 1'b0};
        if (cap_en)   cap_data <= {cap_data[W/2-2:0], sd_i};
      end
    end
  end

  assign sd_o = tx[W-1];
endmodule

// File: rtl/serial_regport_master.sv
module serial_regport_master
  import srm_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int NUM_TGT  = 2,
  localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [TGT_W-1:0]   req_target,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [BYTE_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [BYTE_W-1:0]  rsp_rdata,
  output logic               sclk,
  output logic [NUM_TGT-1:0] cs_n,
  output logic               rw,
  output logic               sd_o,
  output logic               sd_oe,
  input  logic               sd_i
);
  logic              busy, tick, done, accept;
  logic [HCNT_W-1:0] hcnt, hnxt;
  logic              is_read;
  logic [TGT_W-1:0]  tgt_q;
  logic              rise_ev, shift_en, cap_en;
  logic [BYTE_W-1:0] cap_data;
  srm_req_t          req;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign req       = '{write: req_write, index: req_index, wdata: req_wdata};

  srm_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(accept), .run(busy), .tick(tick)
  );

  srm_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .tick(tick),
    .busy(busy), .hcnt(hcnt), .done(done)
  );

  // events on entry into the next half-period
  assign hnxt     = hcnt + 1'b1;
  assign rise_ev  = busy && tick && !hnxt[0] &&
                    (hnxt >= H_FIRST_RISE) && (hnxt <= H_LAST_RISE);
  assign shift_en = rise_ev && (hnxt <= H_LAST_SHIFT);
  assign cap_en   = rise_ev && is_read && (hnxt >= H_FIRST_CAP);

  srm_shifter #(.W(2*BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(srm_frame_word(req)),
    .shift_en(shift_en), .cap_en(cap_en), .sd_i(sd_i),
    .sd_o(sd_o), .cap_data(cap_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_read   <= 1'b0;
      tgt_q     <= '0;
      rsp_rdata <= '0;
    end else if (accept) begin
      is_read   <= !req_write;
      tgt_q     <= req_target;
      rsp_rdata <= '0;
    end else if (busy && tick && (hcnt == H_LAST) && is_read) begin
      rsp_rdata <= cap_data;
    end
  end

  assign rsp_valid = done;

  // pin decode from frame position
  assign sclk  = busy && !hcnt[0] && (hcnt >= H_FIRST_RISE) && (hcnt <= H_LAST_RISE);
  assign rw    = busy && is_read && (hcnt >= H_RW_RISE);
  assign sd_oe = busy && (!is_read || (hcnt < H_RELEASE));

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_cs
    assign cs_n[t] = !(busy && (tgt_q == TGT_W'(t)));
  end
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int NUM_TGT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [7:0]         rsp_rdata,
  input logic               sclk,
  input logic [NUM_TGT-1:0] cs_n,
  input logic               rw,
  input logic               sd_o,
  input logic               sd_oe
);
  // R2: never more than one select low
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R4: driven data moves only with a rising serial clock
  a_r4_sd_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && $past(sd_oe) && (sd_o != $past(sd_o))) |-> $rose(sclk));

  // R6: the line is released only inside a read frame
  a_r6_release_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_oe && !(&cs_n)) |-> rw);

  // R7: serial clock quiet outside frames
  a_r7_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);

  // R8: ready tracks the absence of a frame
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (&cs_n));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: response data moves only at completion or after an accept
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rdata != $past(rsp_rdata)) |-> (rsp_valid || $past(req_valid && req_ready)));
endmodule

bind serial_regport_master srm_checker #(.NUM_TGT(NUM_TGT)) u_srm_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sclk(sclk), .cs_n(cs_n),
  .rw(rw), .sd_o(sd_o), .sd_oe(sd_oe)
);

// File: tb/test_serial_regport_master.sv
module test_serial_regport_master;
  localparam int HD = 2;
  localparam int NT = 3;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [TW-1:0] req_target = '0;
  logic [5:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, sclk, rw, sd_o, sd_oe, sd_i;
  logic [7:0] rsp_rdata;
  logic [NT-1:0] cs_n;

  always #2 clk = ~clk;

  serial_regport_master #(.HALF_DIV(HD), .NUM_TGT(NT)) i_serial_regport_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_target(req_target), .req_index(req_index),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sclk(sclk), .cs_n(cs_n), .rw(rw), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
  );

  int tests = 0, fails = 0, frames = 0, issued = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(int t, int a);
    return 8'((t * 37 + a * 5 + 1) & 8'hff);
  endfunction

  // target model memory and independent shadow
  logic [7:0] tmem   [NT][64];
  logic [7:0] shadow [NT][64];
  initial
    for (int t = 0; t < NT; t++)
      for (int a = 0; a < 64; a++) begin
        tmem[t][a] = init_val(t, a);
        shadow[t][a] = init_val(t, a);
      end

  logic tgt_drive = 1'b0, tgt_bit = 1'b1;
  assign sd_i = sd_oe ? sd_o : (tgt_drive ? tgt_bit : 1'b1);

  // bus monitor and target model, sampled on falling clk
  logic sclk_d = 1'b0, rw_d = 1'b0, sd_d = 1'b1, in_frame = 1'b0, was_read;
  int lead, edges, trail, rw_edge, rw_high, oe_low, oe_after8, tgt, bidx;
  logic [7:0] abyte, dbyte;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!(&cs_n) && !in_frame) begin
        in_frame = 1'b1; lead = 0; edges = 0; trail = 0; rw_edge = -1;
        rw_high = 0; oe_low = 0; oe_after8 = 0; abyte = '0; dbyte = '0;
        was_read = 1'b0; tgt = 0;
        for (int t = 0; t < NT; t++) if (!cs_n[t]) tgt = t;
      end
      if (in_frame && !(&cs_n)) begin
        if (sclk && !sclk_d) begin
          edges++;
          if (edges <= 8) abyte = {abyte[6:0], sd_d};
          else            dbyte = {dbyte[6:0], sd_d};
          if (edges == 8 && rw) begin
            tgt_drive = 1'b1; bidx = 7;
            tgt_bit = tmem[tgt][abyte[6:1]][bidx];
          end else if (tgt_drive && edges < 16) begin
            bidx--; tgt_bit = tmem[tgt][abyte[6:1]][bidx];
          end
        end else if (edges == 0) lead++;
        if (edges == 16 && !sclk) trail++;
        if (rw && !rw_d) rw_edge = edges;
        if (rw) begin rw_high++; was_read = 1'b1; end
        if (!sd_oe) oe_low++;
        if (sd_oe && edges >= 8) oe_after8++;
        if (sd_oe && tgt_drive) chk("R6 contention", 1, 0);
      end
      if (in_frame && (&cs_n)) begin
        in_frame = 1'b0; tgt_drive = 1'b0; frames++;
        chk("R3 edge count", edges, 16);
        chk("R3 address pad bits", {abyte[7], abyte[0]}, 0);
        chk("R7 select lead", lead >= 2*HD, 1);
        chk("R7 select trail", trail >= 2*HD, 1);
        if (was_read) begin
          chk("R6 rw rise between edges 7 and 8", rw_edge, 7);
          chk("R6 released after edge 8", oe_after8, 0);
        end else begin
          chk("R5 rw low in write", rw_high, 0);
          chk("R5 sd driven in write", oe_low, 0);
          tmem[tgt][abyte[6:1]] = dbyte;
        end
      end
    end
    sclk_d = sclk; rw_d = rw; sd_d = sd_i;
  end

  // scoreboard
  logic [7:0] expq[$];
  logic rv_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (rv_d) chk("R9 pulse width", 1, 0);
      if (expq.size() == 0) chk("R9 unexpected response", 1, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk("R9 response data (R3 R5 R6)", rsp_rdata, e);
      end
    end
    rv_d = rsp_valid;
  end

  task automatic do_req(logic wr, int t, int idx, logic [7:0] wd);
    if (wr) begin shadow[t][idx] = wd; expq.push_back(8'h00); end
    else expq.push_back(shadow[t][idx]);
    issued++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_target = TW'(t);
    req_index = 6'(idx); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ready low while busy", req_ready, 0);
    while (expq.size() != 0) @(negedge clk);
  endtask

  int cyc = 0;
  initial begin
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    chk("watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n idle", cs_n, {NT{1'b1}});
    chk("R1 sclk idle", sclk, 0);
    chk("R1 rw idle", rw, 0);
    chk("R1 sd_oe idle", sd_oe, 0);
    chk("R1 rsp_valid idle", rsp_valid, 0);
    chk("R1 req_ready idle", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 reads of initial contents, R2 different targets
    do_req(1'b0, 0, 0, 8'h00);
    do_req(1'b0, 2, 63, 8'h00);
    // R5 writes then readback
    do_req(1'b1, 1, 10, 8'hA5);
    do_req(1'b0, 1, 10, 8'h00);
    do_req(1'b1, 0, 63, 8'h5A);
    do_req(1'b0, 0, 63, 8'h00);
    do_req(1'b1, 2, 0, 8'hFF);
    do_req(1'b0, 2, 0, 8'h00);
    do_req(1'b1, 2, 33, 8'h00);
    do_req(1'b0, 2, 33, 8'h00);
    do_req(1'b0, 0, 10, 8'h00);  // R2: target 1 write did not touch target 0

    // R8: request while busy is ignored
    begin
      int f0;
      f0 = frames;
      shadow[1][5] = 8'h3C; expq.push_back(8'h00); issued++;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_target = 2'd1;
      req_index = 6'd5; req_wdata = 8'h3C;
      @(negedge clk);
      req_target = 2'd2; req_index = 6'd7; req_wdata = 8'h99;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
      while (expq.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R8 one frame for busy request", frames - f0, 1);
      do_req(1'b0, 2, 7, 8'h00);   // must still hold initial value
      do_req(1'b0, 1, 5, 8'h00);
    end

    // R9 hold after read and after write
    do_req(1'b0, 1, 10, 8'h00);
    repeat (20) @(negedge clk);
    chk("R9 read data held", rsp_rdata, 8'hA5);
    do_req(1'b1, 0, 1, 8'h77);
    repeat (10) @(negedge clk);
    chk("R9 write result zero held", rsp_rdata, 8'h00);

    repeat (10) @(negedge clk);
    chk("R8 frames equal requests", frames, issued);
    chk("R9 scoreboard drained", expq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule